// File: doc/BRIEF.md
# T1 Superframe F-bit Multiplexer

This block paces the transmit side of a T1 line. It counts the 193 bit times of each frame and the frames of a superframe. In the first bit time of every frame it places a framing bit on the line. In the other 192 bit times it passes the serial channel data through, in the order it arrives, so the most significant bit of each channel goes first. One mode input picks a 12-frame superframe or a 24-frame extended superframe.

In the 12-frame mode, odd frames carry the terminal alignment pattern and even frames carry the signaling alignment pattern.

In the 24-frame mode, the framing bit position is shared by three sources, chosen by frame number:
- a fixed six-bit framing pattern;
- a 4 kHz maintenance link, taken from a link input;
- six check bits, taken from a parallel input or from the serial data input.

The link source is given a one-cycle request strobe one bit time before each link bit is used. Frame and superframe strobes mark the last bit time of a frame, so frame 1 begins on the cycle after a superframe strobe.

A three-state machine sequences each frame:
- PH_FBIT is the framing bit time. It always moves to PH_CHAN.
- PH_CHAN covers channel bits 1 to 191. It moves to PH_EOF once bit 191 is done.
- PH_EOF is bit 192. It always returns to PH_FBIT, and it advances the frame number or wraps it to 1.

Synchronous reset forces PH_FBIT, bit 0, frame 1.

Top module: `t1_fbit_mux`

## Requirements
- R1: A frame lasts exactly 193 clock cycles. `frame_sync` is high only in the last of them (bit 192), and the next cycle is the framing bit of the next frame.
- R2: Frames are numbered from 1. The number advances by one per frame and wraps to 1 after frame 12 when `esf_mode`=0, or after frame 24 when `esf_mode`=1. `sf_sync` is high only during bit 192 of the last frame.
- R3: In bit times 1 to 192, `line_out` equals `ser_in` in the same cycle.
- R4: With `esf_mode`=1, the framing bit of frames 4, 8, 12, 16, 20 and 24 is 0, 0, 1, 0, 1, 1 respectively.
- R5: With `esf_mode`=1, the framing bit of every odd frame equals `link_in` in that cycle.
- R6: With `esf_mode`=1 and `ext_crc`=0, the framing bit of frame 4k-2 (k=1..6) equals `crc_in[k-1]`.
- R7: With `esf_mode`=1 and `ext_crc`=1, the framing bit of frames 2, 6, 10, 14, 18 and 22 equals `ser_in` in that cycle. In this case `crc_in` has no effect, and the other frames are unchanged.
- R8: With `esf_mode`=0, the framing bit of frames 1, 3, 5, 7, 9 and 11 is 1, 0, 1, 0, 1, 0 respectively.
- R9: With `esf_mode`=0, the framing bit of frames 2, 4, 6, 8, 10 and 12 is 0, 0, 1, 1, 1, 0 respectively.
- R10: `link_req` is high exactly during bit 192 of even frames when `esf_mode`=1, and it is never high when `esf_mode`=0.
- R11: While `rst` is high at a clock edge, the next cycle is bit 0 of frame 1. This holds from any point in a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| esf_mode | input | 1 | 1 selects the 24-frame superframe, 0 the 12-frame one |
| ext_crc | input | 1 | 1 takes check bits from `ser_in` at framing bit time |
| crc_in | input | 6 | Check bits; bit k-1 holds check bit k |
| link_in | input | 1 | Maintenance link bit |
| ser_in | input | 1 | Serial channel data |
| line_out | output | 1 | Transmit line bit |
| frame_sync | output | 1 | High in the last bit time of each frame |
| sf_sync | output | 1 | High in the last bit time of a superframe |
| link_req | output | 1 | Request for the next link bit |

## Verification
The hardest case to reach is the external check-bit path. It needs the 24-frame mode, `ext_crc` high, and the framing bit time of one of six particular frames, while `crc_in` and `ser_in` differ. The stimulus re-draws `ext_crc` and `crc_in` at the start of every frame and randomizes `ser_in` every cycle, across three full 24-frame superframes. This way both check-bit sources and the unaffected link and pattern frames are all seen in every combination. A reset driven in the middle of a frame, and the wraps after frames 12 and 24, are forced by directed sequences.

// File: rtl/t1fm_pkg.sv
package t1fm_pkg;
    localparam logic [5:0] ESF_PATTERN  = 6'b110100; // slot i -> bit i
    localparam logic [5:0] D4_TERMINAL  = 6'b010101;
    localparam logic [5:0] D4_SIGNALING = 6'b011100;

    typedef enum logic [1:0] {
        PH_FBIT,
        PH_CHAN,
        PH_EOF
    } phase_t;

    typedef enum logic [2:0] {
        SRC_LINK,
        SRC_CRC,
        SRC_EXT,
        SRC_FPS,
        SRC_TERM,
        SRC_SIG
    } fsrc_t;
endpackage

// File: rtl/t1fm_timing.sv
module t1fm_timing
    import t1fm_pkg::*;
#(
    parameter int CHANNELS = 24,
    parameter int CH_BITS  = 8,
    parameter int D4_LEN   = 12,
    parameter int ESF_LEN  = 24,
    parameter int FRW      = 5
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           esf_mode,
    output logic [FRW-1:0] frame_no,
    output logic           fbit_slot,
    output logic           frame_end,
    output logic           sf_end,
    output logic           link_pre
);
    localparam int LAST_BIT = CHANNELS * CH_BITS;
    localparam int BCW      = $clog2(LAST_BIT + 1);

    phase_t         state, state_nx;
    logic [BCW-1:0] bit_idx, bit_nx;
    logic [FRW-1:0] frame_nx, last_frame;

    assign last_frame = esf_mode ? FRW'(ESF_LEN) : FRW'(D4_LEN);

    always_comb begin
        state_nx = state;
        bit_nx   = bit_idx + BCW'(1);
        frame_nx = frame_no;
        unique case (state)
            PH_FBIT: state_nx = PH_CHAN;
            PH_CHAN: if (bit_idx == BCW'(LAST_BIT - 1)) state_nx = PH_EOF;
            PH_EOF: begin
                state_nx = PH_FBIT;
                bit_nx   = '0;
                frame_nx = (frame_no >= last_frame) ? FRW'(1) : frame_no + FRW'(1);
            end
            default: begin
                state_nx = PH_FBIT;
                bit_nx   = '0;
                frame_nx = FRW'(1);
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= PH_FBIT;
            bit_idx  <= '0;
            frame_no <= FRW'(1);
        end else begin
            state    <= state_nx;
            bit_idx  <= bit_nx;
            frame_no <= frame_nx;
        end
    end

    always_comb begin
        fbit_slot = 1'b0;
        frame_end = 1'b0;
        sf_end    = 1'b0;
        link_pre  = 1'b0;
        unique case (state)
            PH_FBIT: fbit_slot = 1'b1;
            PH_CHAN: ;
            PH_EOF: begin
                frame_end = 1'b1;
                sf_end    = (frame_no >= last_frame);
                link_pre  = esf_mode && !frame_no[0];
            end
            default: ;
        endcase
    end

    AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> (bit_idx == '0 && fbit_slot)); // R1
    AST_FRAME_LEN: assert property (@(posedge clk) disable iff (rst)
        frame_end |-> (bit_idx == BCW'(LAST_BIT))); // R1
    AST_FRAME_STEP: assert property (@(posedge clk) disable iff (rst)
        (frame_end && !sf_end) |=> (frame_no == $past(frame_no) + FRW'(1))); // R2
    AST_SF_WRAP: assert property (@(posedge clk) disable iff (rst)
        sf_end |=> (frame_no == FRW'(1))); // R2
    AST_RESET_START: assert property (@(posedge clk)
        rst |=> (bit_idx == '0 && frame_no == FRW'(1) && fbit_slot)); // R11
endmodule

// File: rtl/t1fm_fbit_sel.sv
module t1fm_fbit_sel
    import t1fm_pkg::*;
#(
    parameter int CRC_W = 6,
    parameter int FRW   = 5
) (
    input  logic             esf_mode,
    input  logic             ext_crc,
    input  logic [FRW-1:0]   frame_no,
    input  logic [CRC_W-1:0] crc_bits,
    input  logic             link_bit,
    input  logic             ser_bit,
    output logic             fbit
);
    fsrc_t          src;
    logic [2:0]     slot;
    logic [FRW-1:0] half;
    logic [FRW-1:0] quarter;

    always_comb begin
        half    = (frame_no - FRW'(1)) >> 1;
        quarter = frame_no >> 2;
        if (esf_mode) begin
            if (frame_no[0]) begin
                src  = SRC_LINK;
                slot = 3'd0;
            end else if (frame_no[1]) begin
                src  = ext_crc ? SRC_EXT : SRC_CRC;
                slot = 3'(quarter);
            end else begin
                src  = SRC_FPS;
                slot = 3'(quarter - FRW'(1));
            end
        end else begin
            src  = frame_no[0] ? SRC_TERM : SRC_SIG;
            slot = 3'((half >= FRW'(6)) ? half - FRW'(6) : half);
        end
    end

    always_comb begin
        unique case (src)
            SRC_LINK: fbit = link_bit;
            SRC_CRC:  fbit = crc_bits[slot];
            SRC_EXT:  fbit = ser_bit;
            SRC_FPS:  fbit = ESF_PATTERN[slot];
            SRC_TERM: fbit = D4_TERMINAL[slot];
            SRC_SIG:  fbit = D4_SIGNALING[slot];
            default:  fbit = 1'b0;
        endcase
    end
endmodule

// File: rtl/t1_fbit_mux.sv
module t1_fbit_mux
    import t1fm_pkg::*;
#(
    parameter int CHANNELS = 24,
    parameter int CH_BITS  = 8,
    parameter int D4_LEN   = 12,
    parameter int ESF_LEN  = 24,
    parameter int CRC_W    = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             esf_mode,
    input  logic             ext_crc,
    input  logic [CRC_W-1:0] crc_in,
    input  logic             link_in,
    input  logic             ser_in,
    output logic             line_out,
    output logic             frame_sync,
    output logic             sf_sync,
    output logic             link_req
);
    localparam int FRW = $clog2(ESF_LEN + 1);

    logic [FRW-1:0] frame_no;
    logic           fbit_slot;
    logic           fbit;

    t1fm_timing #(
        .CHANNELS(CHANNELS), .CH_BITS(CH_BITS),
        .D4_LEN(D4_LEN), .ESF_LEN(ESF_LEN), .FRW(FRW)
    ) u_timing (
        .clk(clk), .rst(rst), .esf_mode(esf_mode),
        .frame_no(frame_no), .fbit_slot(fbit_slot),
        .frame_end(frame_sync), .sf_end(sf_sync), .link_pre(link_req)
    );

    t1fm_fbit_sel #(.CRC_W(CRC_W), .FRW(FRW)) u_sel (
        .esf_mode(esf_mode), .ext_crc(ext_crc), .frame_no(frame_no),
        .crc_bits(crc_in), .link_bit(link_in), .ser_bit(ser_in), .fbit(fbit)
    );

    assign line_out = fbit_slot ? fbit : ser_in;

    AST_LINK_REQ_NEXT: assert property (@(posedge clk) disable iff (rst)
        link_req |=> (fbit_slot && frame_no[0] && esf_mode)); // R10
    AST_EXT_CRC_PASS: assert property (@(posedge clk) disable iff (rst)
        (fbit_slot && esf_mode && ext_crc && frame_no[1:0] == 2'b10) |-> (line_out == ser_in)); // R7
    AST_SF_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        sf_sync |-> frame_sync); // R2
    AST_NO_REQ_D4: assert property (@(posedge clk) disable iff (rst)
        !esf_mode |-> !link_req); // R10
endmodule

// File: tb/t1_fbit_mux_test.sv
`timescale 1ns/1ps
module t1_fbit_mux_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic esf_mode = 1'b0, ext_crc = 1'b0, link_in = 1'b0, ser_in = 1'b0;
    logic [5:0] crc_in = '0;
    logic line_out, frame_sync, sf_sync, link_req;

    int checks = 0, failures = 0, cyc = 0;
    int mb = 0, mf = 1;
    bit done = 1'b0;

    always #4 clk = ~clk;

    t1_fbit_mux uut (
        .clk(clk), .rst(rst), .esf_mode(esf_mode), .ext_crc(ext_crc),
        .crc_in(crc_in), .link_in(link_in), .ser_in(ser_in),
        .line_out(line_out), .frame_sync(frame_sync), .sf_sync(sf_sync),
        .link_req(link_req)
    );

    function automatic logic exp_fbit(int f, logic esf, logic ext,
                                      logic [5:0] crc, logic lnk, logic ser);
        bit fps[6]  = '{0, 0, 1, 0, 1, 1};
        bit term[6] = '{1, 0, 1, 0, 1, 0};
        bit sig[6]  = '{0, 0, 1, 1, 1, 0};
        if (esf) begin
            if (f % 2 == 1) return lnk;
            if (f % 4 == 2) return ext ? ser : crc[(f - 2) / 4];
            return fps[f / 4 - 1];
        end
        if (f % 2 == 1) return term[(f - 1) / 2];
        return sig[f / 2 - 1];
    endfunction

    function automatic string fbit_tag(int f, logic esf, logic ext);
        if (!esf) return (f % 2 == 1) ? "R8" : "R9";
        if (f % 2 == 1) return "R5";
        if (f % 4 == 2) return ext ? "R7" : "R6";
        return "R4";
    endfunction

    task automatic chk(logic got, logic exp, string tag, string what);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s bit=%0d frame=%0d got=%b exp=%b", tag, what, mb, mf, got, exp);
        end
    endtask

    task automatic step(logic r, bit rand_ext);
        int last;
        @(negedge clk);
        rst     = r;
        ser_in  = 1'($urandom);
        link_in = 1'($urandom);
        if (mb == 0) begin
            crc_in = 6'($urandom);
            if (rand_ext) ext_crc = 1'($urandom);
        end
        #1;
        last = esf_mode ? 24 : 12;
        if (mb == 0)
            chk(line_out, exp_fbit(mf, esf_mode, ext_crc, crc_in, link_in, ser_in),
                fbit_tag(mf, esf_mode, ext_crc), "fbit");
        else
            chk(line_out, ser_in, "R3", "channel");
        chk(frame_sync, logic'(mb == 192), "R1", "frame_sync");
        chk(sf_sync, logic'(mb == 192 && mf == last), "R2", "sf_sync");
        chk(link_req, logic'(esf_mode && mb == 192 && mf % 2 == 0), "R10", "link_req");
        if (r) begin
            mb = 0; mf = 1;
        end else if (mb == 192) begin
            mb = 0; mf = (mf >= last) ? 1 : mf + 1;
        end else begin
            mb++;
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // R11: reset state
        repeat (3) step(1'b1, 1'b0);
        // D4: R8 R9 across two superframes plus wrap after frame 12
        for (int i = 0; i < 2 * 12 * 193 + 50; i++) step(1'b0, 1'b0);
        // R11: mid-frame reset restarts at frame 1 bit 0
        step(1'b1, 1'b0);
        for (int i = 0; i < 700; i++) step(1'b0, 1'b0);
        // ESF with randomized check-bit source per frame
        esf_mode = 1'b1;
        step(1'b1, 1'b0);
        for (int i = 0; i < 3 * 24 * 193; i++) step(1'b0, 1'b1);
        // Directed: external check bits held on for a whole superframe (R7)
        ext_crc = 1'b1;
        for (int i = 0; i < 24 * 193; i++) step(1'b0, 1'b0);
        // Directed: internal check bits only (R6), reset inside a frame (R11)
        ext_crc = 1'b0;
        for (int i = 0; i < 1000; i++) step(1'b0, 1'b0);
        step(1'b1, 1'b0);
        for (int i = 0; i < 24 * 193 + 10; i++) step(1'b0, 1'b0);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule